// File: doc/BRIEF.md
# Sample-Ready Interrupt Pin Generator

This block drives a single interrupt pin that tells a host when a sensor's output path holds fresh samples. New-sample strobes from the rate channels, and optionally from the temperature channel, set the interrupt. Register-read strobes from the host's register port clear it. The pin then goes through a polarity and drive-style stage before it reaches the pad: the pad logic gets a data value and an output enable.

The block has two modes. In held mode, which is the default, the interrupt stays up after a sample arrives. It drops only when the host reads one of three registers: the upper byte of either axis result, or the status register. In timed mode, every new sample produces a pulse of fixed length, and host reads have no effect on it. The pulse length is set in nanoseconds. It is turned into system clock cycles from the clock frequency given as a parameter.

Timing: every strobe is sampled on a rising clock edge, and the interrupt state it produces is visible on the outputs right after that edge. Configuration inputs act combinationally on the pad stage.

Top module: `drdy_irq_gen`

## Requirements
- R1: While `cfg_enable` is 0, the interrupt is deasserted, and both held and timed state are cleared. After the block is re-enabled, the interrupt stays deasserted until the next qualifying sample.
- R2: In held mode (`cfg_timed`=0), a qualifying sample asserts the interrupt from the clock edge that samples it. The interrupt stays asserted until it is cleared.
- R3: In held mode, a strobe on `rd_x_high`, `rd_y_high` or `rd_status` deasserts the interrupt from the clock edge that samples it.
- R4: In held mode, a strobe on `rd_other` (a read of any other register) leaves the interrupt unchanged.
- R5: In held mode, if a qualifying sample and a clearing read fall in the same cycle, the interrupt is asserted after that edge.
- R6: In timed mode (`cfg_timed`=1), each qualifying sample asserts the interrupt for exactly PULSE_CYCLES clock cycles, where PULSE_CYCLES = ceil(CLK_FREQ_KHZ*PULSE_NS/1e6) with a minimum of 1. Read strobes have no effect in this mode.
- R7: In timed mode, a sample that arrives during a pulse restarts the full PULSE_CYCLES count.
- R8: `smp_temp_new` counts as a qualifying sample only when `cfg_temp_flag` is 1. `smp_rate_new` always counts.
- R9: The pin level is the interrupt state when `cfg_active_low`=0, and its inverse when `cfg_active_low`=1.
- R10: With `cfg_open_drain`=0, `pin_oe` is 1 and `pin_out` is the pin level. With `cfg_open_drain`=1, `pin_out` is 0, and `pin_oe` is 1 only while the pin level is 0.
- R11: After a synchronous reset, the interrupt is deasserted in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_rate_new | input | 1 | One-cycle strobe: new rate sample set ready |
| smp_temp_new | input | 1 | One-cycle strobe: new temperature sample ready |
| rd_x_high | input | 1 | One-cycle strobe: host read the X result upper byte |
| rd_y_high | input | 1 | One-cycle strobe: host read the Y result upper byte |
| rd_status | input | 1 | One-cycle strobe: host read the status register |
| rd_other | input | 1 | One-cycle strobe: host read any other register |
| cfg_enable | input | 1 | 1 routes the interrupt to the pin |
| cfg_timed | input | 1 | 0 held mode, 1 timed pulse mode |
| cfg_active_low | input | 1 | 1 inverts pin polarity |
| cfg_open_drain | input | 1 | 1 selects open-drain drive |
| cfg_temp_flag | input | 1 | 1 lets temperature samples raise the interrupt |
| pin_out | output | 1 | Pad data value |
| pin_oe | output | 1 | Pad output enable |

## Verification
Two cases are hard to reach. The first is a sample and a clearing read in the very same cycle. The second is a second sample landing in the middle of a running pulse. The bench drives these from one task that asserts any set of strobes together for one cycle, and it places the retrigger a known number of cycles into the pulse. Each of these scenarios runs under all four polarity and drive-style combinations. Every pad value is predicted from the expected interrupt state and the current configuration. This means open-drain release, inverted polarity and pulse length are all checked at the pad ports.

// File: rtl/drdy_pkg.sv
package drdy_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_HELD  = 2'd1,
        MODE_TIMED = 2'd2
    } irq_mode_e;

    typedef struct packed {
        logic enable;
        logic timed;
        logic active_low;
        logic open_drain;
        logic temp_flag;
    } irq_cfg_t;

    typedef struct packed {
        logic oe;
        logic dat;
    } pad_t;

    // Cycles for a pulse of dur_ns at clk_khz, rounded up, at least one.
    function automatic int unsigned pulse_cycles(input longint clk_khz, input longint dur_ns);
        longint c;
        c = (clk_khz * dur_ns + 64'd999_999) / 64'd1_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic irq_mode_e pick_mode(input irq_cfg_t cfg);
        if (!cfg.enable)   return MODE_OFF;
        else if (cfg.timed) return MODE_TIMED;
        else               return MODE_HELD;
    endfunction

    function automatic pad_t pad_encode(input logic active, input logic act_low, input logic od);
        pad_t p;
        logic lvl;
        lvl = active ^ act_low;
        if (od) begin
            p.oe  = ~lvl;
            p.dat = 1'b0;
        end else begin
            p.oe  = 1'b1;
            p.dat = lvl;
        end
        return p;
    endfunction

endpackage

// File: rtl/drdy_event_merge.sv
module drdy_event_merge
    import drdy_pkg::*;
(
    input  logic      smp_rate_new,
    input  logic      smp_temp_new,
    input  logic      rd_x_high,
    input  logic      rd_y_high,
    input  logic      rd_status,
    input  irq_cfg_t  cfg,
    output logic      evt,
    output logic      clr,
    output irq_mode_e mode
);
    always_comb begin
        evt  = smp_rate_new | (cfg.temp_flag & smp_temp_new);
        clr  = rd_x_high | rd_y_high | rd_status;
        mode = pick_mode(cfg);
    end
endmodule

// File: rtl/drdy_held.sv
module drdy_held
    import drdy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_mode_e mode,
    input  logic      evt,
    input  logic      clr,
    output logic      active
);
    logic lvl_q;
    logic run;

    assign run    = (mode == MODE_HELD);
    assign active = lvl_q;

    always_ff @(posedge clk) begin
        if (rst)       lvl_q <= 1'b0;
        else if (!run) lvl_q <= 1'b0;
        else if (evt)  lvl_q <= 1'b1;
        else if (clr)  lvl_q <= 1'b0;
    end

    AST_SAMPLE_BEATS_READ: assert property (@(posedge clk) disable iff (rst)
        (run && evt && clr) |=> lvl_q); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (run && clr && !evt) |=> !lvl_q); // R3
    AST_HELD_STAYS: assert property (@(posedge clk) disable iff (rst)
        (run && lvl_q && !clr && !evt) |=> lvl_q); // R2
    AST_OFF_CLEARS_HELD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |=> !lvl_q); // R1
endmodule

// File: rtl/drdy_timed.sv
module drdy_timed
    import drdy_pkg::*;
#(
    parameter int unsigned CYCLES = 8,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  irq_mode_e mode,
    input  logic      evt,
    output logic      active
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;
    logic             run;

    assign run    = (mode == MODE_TIMED);
    assign active = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (!run)          cnt_q <= '0;
        else if (evt)           cnt_q <= LOAD;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (run && evt) |=> (cnt_q == LOAD)); // R7
    AST_PULSE_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
        (run && !evt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6
    AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (run && !evt && cnt_q == '0) |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/drdy_pad.sv
module drdy_pad
    import drdy_pkg::*;
(
    input  logic     active,
    input  irq_cfg_t cfg,
    output pad_t     pad
);
    always_comb pad = pad_encode(active, cfg.active_low, cfg.open_drain);

    always_comb begin
        if (cfg.open_drain)
            AST_OD_NEVER_DRIVES_HIGH: assert (!(pad.oe && pad.dat)); // R10
        else
            AST_PP_ALWAYS_DRIVES: assert (pad.oe); // R10
    end
endmodule

// File: rtl/drdy_irq_gen.sv
module drdy_irq_gen
    import drdy_pkg::*;
#(
    parameter longint CLK_FREQ_KHZ = 100_000,
    parameter longint PULSE_NS     = 75_000,
    localparam int unsigned PULSE_CYCLES = pulse_cycles(CLK_FREQ_KHZ, PULSE_NS)
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_rate_new,
    input  logic smp_temp_new,
    input  logic rd_x_high,
    input  logic rd_y_high,
    input  logic rd_status,
    input  logic rd_other,
    input  logic cfg_enable,
    input  logic cfg_timed,
    input  logic cfg_active_low,
    input  logic cfg_open_drain,
    input  logic cfg_temp_flag,
    output logic pin_out,
    output logic pin_oe
);
    irq_cfg_t  cfg;
    irq_mode_e mode;
    logic      evt, clr;
    logic      held_act, timed_act, irq_act;
    pad_t      pad;
    logic      unused_rd;

    assign cfg = '{enable: cfg_enable, timed: cfg_timed, active_low: cfg_active_low,
                   open_drain: cfg_open_drain, temp_flag: cfg_temp_flag};
    // Reads of unrelated registers are accepted at the port and intentionally discarded.
    assign unused_rd = rd_other;

    drdy_event_merge u_merge (
        .smp_rate_new (smp_rate_new),
        .smp_temp_new (smp_temp_new),
        .rd_x_high    (rd_x_high),
        .rd_y_high    (rd_y_high),
        .rd_status    (rd_status),
        .cfg          (cfg),
        .evt          (evt),
        .clr          (clr),
        .mode         (mode)
    );

    drdy_held u_held (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .evt    (evt),
        .clr    (clr),
        .active (held_act)
    );

    drdy_timed #(.CYCLES(PULSE_CYCLES)) u_timed (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .evt    (evt),
        .active (timed_act)
    );

    always_comb begin
        unique case (mode)
            MODE_HELD:  irq_act = held_act;
            MODE_TIMED: irq_act = timed_act;
            default:    irq_act = 1'b0;
        endcase
    end

    drdy_pad u_pad (
        .active (irq_act),
        .cfg    (cfg),
        .pad    (pad)
    );

    assign pin_out = pad.dat;
    assign pin_oe  = pad.oe;

    AST_DISABLED_PIN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !cfg_open_drain) |-> (pin_out == cfg_active_low)); // R1
    AST_HELD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(held_act && timed_act)); // R6
endmodule

// File: tb/drdy_irq_gen_bench.sv
module drdy_irq_gen_bench;
    localparam longint KHZ = 100_000;
    localparam longint PNS = 1_000;
    localparam int P = int'((KHZ * PNS + 999_999) / 1_000_000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_rate_new = 0, smp_temp_new = 0;
    logic rd_x_high = 0, rd_y_high = 0, rd_status = 0, rd_other = 0;
    logic cfg_enable = 0, cfg_timed = 0, cfg_active_low = 0, cfg_open_drain = 0, cfg_temp_flag = 0;
    logic pin_out, pin_oe;
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #5 clk = ~clk;

    drdy_irq_gen #(.CLK_FREQ_KHZ(KHZ), .PULSE_NS(PNS)) u_drdy_irq_gen (
        .clk(clk), .rst(rst),
        .smp_rate_new(smp_rate_new), .smp_temp_new(smp_temp_new),
        .rd_x_high(rd_x_high), .rd_y_high(rd_y_high), .rd_status(rd_status), .rd_other(rd_other),
        .cfg_enable(cfg_enable), .cfg_timed(cfg_timed), .cfg_active_low(cfg_active_low),
        .cfg_open_drain(cfg_open_drain), .cfg_temp_flag(cfg_temp_flag),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [1:0] want_pad(input logic act);
        logic lvl;
        lvl = act ^ cfg_active_low;
        if (cfg_open_drain) return {~lvl, 1'b0};
        return {1'b1, lvl};
    endfunction

    function automatic logic pin_active();
        logic lvl;
        lvl = cfg_open_drain ? ~pin_oe : pin_out;
        return lvl ^ cfg_active_low;
    endfunction

    task automatic check(input logic exp_act, input string tag);
        logic [1:0] w;
        w = want_pad(exp_act);
        compared++;
        if ({pin_oe, pin_out} !== w) begin
            mismatched++;
            $display("FAIL %s: oe/out=%b%b expected %b%b (al=%0b od=%0b)",
                     tag, pin_oe, pin_out, w[1], w[0], cfg_active_low, cfg_open_drain);
        end
    endtask

    // Drive a set of strobes for exactly one rising edge; returns at the next falling edge.
    task automatic strobe(input logic r, input logic t, input logic rx, input logic ry,
                          input logic rs, input logic ro);
        smp_rate_new = r; smp_temp_new = t;
        rd_x_high = rx; rd_y_high = ry; rd_status = rs; rd_other = ro;
        @(negedge clk);
        smp_rate_new = 0; smp_temp_new = 0;
        rd_x_high = 0; rd_y_high = 0; rd_status = 0; rd_other = 0;
    endtask

    task automatic measure_pulse(input string tag);
        int n;
        n = 0;
        rd_x_high = 1; rd_y_high = 1; rd_status = 1; rd_other = 1;
        while (pin_active() && n < 4 * P) begin
            n++;
            @(negedge clk);
        end
        rd_x_high = 0; rd_y_high = 0; rd_status = 0; rd_other = 0;
        compared++;
        if (n != P) begin
            mismatched++;
            $display("FAIL %s: pulse cycles=%0d expected %0d", tag, n, P);
        end
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int combo = 0; combo < 4; combo++) begin
            @(negedge clk);
            rst = 1; cfg_enable = 0; cfg_timed = 0; cfg_temp_flag = 0;
            cfg_active_low = combo[0]; cfg_open_drain = combo[1];
            repeat (2) @(negedge clk);
            rst = 0;
            check(1'b0, "R11 reset idle");
            // R9 R10 pad encoding, deasserted state
            check(1'b0, "R9 R10 idle pad");

            strobe(1, 0, 0, 0, 0, 0);
            check(1'b0, "R1 sample while disabled");
            cfg_enable = 1;
            @(negedge clk);
            check(1'b0, "R1 no stale assertion after enable");

            strobe(1, 0, 0, 0, 0, 0);
            check(1'b1, "R2 sample asserts");
            repeat (3) @(negedge clk);
            check(1'b1, "R2 held without reads");
            strobe(0, 0, 0, 0, 0, 1);
            check(1'b1, "R4 unrelated read ignored");
            strobe(0, 0, 1, 0, 0, 0);
            check(1'b0, "R3 X high read clears");
            strobe(1, 0, 0, 0, 0, 0);
            strobe(0, 0, 0, 1, 0, 0);
            check(1'b0, "R3 Y high read clears");
            strobe(1, 0, 0, 0, 0, 0);
            strobe(0, 0, 0, 0, 1, 0);
            check(1'b0, "R3 status read clears");
            strobe(1, 0, 1, 1, 1, 0);
            check(1'b1, "R5 sample beats same-cycle read");
            strobe(0, 0, 0, 0, 1, 0);
            strobe(0, 1, 0, 0, 0, 0);
            check(1'b0, "R8 temp sample ignored when flag clear");
            cfg_temp_flag = 1;
            strobe(0, 1, 0, 0, 0, 0);
            check(1'b1, "R8 temp sample asserts when flag set");

            cfg_enable = 0;
            @(negedge clk);
            check(1'b0, "R1 disable drops pin");
            cfg_enable = 1;
            @(negedge clk);
            check(1'b0, "R1 held state cleared by disable");

            cfg_timed = 1; cfg_temp_flag = 0;
            @(negedge clk);
            check(1'b0, "R6 timed mode idle");
            strobe(1, 0, 0, 0, 0, 0);
            measure_pulse("R6 pulse width with reads");
            check(1'b0, "R6 pulse ended");

            strobe(1, 0, 0, 0, 0, 0);
            repeat (P / 2) @(negedge clk);
            check(1'b1, "R7 mid pulse");
            strobe(1, 0, 0, 0, 0, 0);
            measure_pulse("R7 retrigger restarts count");

            strobe(0, 1, 0, 0, 0, 0);
            check(1'b0, "R8 timed temp ignored without flag");
            cfg_temp_flag = 1;
            strobe(0, 1, 0, 0, 0, 0);
            measure_pulse("R8 timed temp pulse");

            strobe(1, 0, 0, 0, 0, 0);
            rst = 1;
            @(negedge clk);
            rst = 0;
            check(1'b0, "R11 reset stops pulse");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule